// File: doc/BRIEF.md
# Decoded Micro-op Loop Buffer

This block sits between an instruction decoder and the execution back end. In normal operation it forwards the decoded micro-op stream unchanged and keeps a copy of each accepted micro-op in a small store. It watches for a taken branch whose target tag names a micro-op that is still held in the store. That is a short backward loop. The loop body has to be seen complete a second time with the same length before the body is locked.

Once the body is locked, the block stops accepting input and replays the body from its own storage. It wraps from the entry that holds the closing branch back to the loop head. While it replays, it raises three gating outputs so that the fetch unit, the branch predictor and the decoder can be powered down. A loop-exit indication or a flush/mispredict drops the locked body and returns the block to pass-through. A body longer than the storage depth (28 by default) is never locked, because it cannot fit.

Top module: `uop_loop_buffer`

## Requirements
- R1: In pass-through mode, `out_valid`, `out_uop`, `out_tag` and `out_taken` equal the input fields in the same cycle, and `in_ready` equals `out_ready`.
- R2: A taken branch whose target tag matches a recorded micro-op, or the branch's own tag, marks a loop candidate. The body is locked only when the next pass closes with a taken branch to the same head tag at the same length. In the cycle after the closing branch is accepted, `out_valid` and `in_ready` are low. Replay output starts in the cycle after that.
- R3: A body of at most DEPTH (28) micro-ops can be locked. A longer body is never locked, and a recording that fills the store without a loop is discarded.
- R4: During replay `out_valid` is high, and the output walks the body in recorded order from the head to the closing branch (`out_taken` = 1 only on that last entry), then wraps to the head.
- R5: During replay the read position advances only in a cycle with `out_ready` high. While `out_ready` is low, the same micro-op is held on the outputs.
- R6: `gate_fetch`, `gate_bpred` and `gate_decode` are all high in replay and all low in every other mode. `in_ready` is low whenever the gates are high.
- R7: `loop_exit` or `flush` in any mode returns the block to pass-through on the next cycle with the gates low and the recording cleared. A loop seen after that must again pass twice before it is locked.
- R8: When `flush` arrives in the same cycle as the closing branch of the second pass, the flush wins: no body is locked and pass-through continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Decoder micro-op valid |
| in_uop | input | UOP_W | Decoded micro-op payload |
| in_tag | input | TAG_W | Tag (address) of this micro-op |
| in_taken | input | 1 | Micro-op is a taken branch |
| in_target | input | TAG_W | Tag of the taken branch's target |
| loop_exit | input | 1 | Loop has been left; stop replay |
| flush | input | 1 | Mispredict or pipeline flush |
| in_ready | output | 1 | Block accepts the input micro-op |
| out_valid | output | 1 | Output micro-op valid |
| out_uop | output | UOP_W | Output micro-op payload |
| out_tag | output | TAG_W | Output micro-op tag |
| out_taken | output | 1 | Output micro-op is a taken branch |
| out_ready | input | 1 | Back end accepts the output |
| gate_fetch | output | 1 | Disable fetch unit |
| gate_bpred | output | 1 | Disable branch predictor |
| gate_decode | output | 1 | Disable decoder |

## Verification
Two actions can fall on the same clock edge: locking a loop, when the second pass closes, and the flush that clears the recording. The bench drives `flush` high together with the closing branch of a second pass. It judges the result at the ports: the gates must stay low, the block must keep forwarding, a third pass must still be forwarded, and only a fourth pass may lock the loop. A loop exit that arrives during a replay handshake is also checked, by watching the gates fall and pass-through return on the next cycle.

// File: rtl/uloop_pkg.sv
// Package: shared types for the micro-op loop buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package uloop_pkg;

    // Operating mode of the loop buffer.
    typedef enum logic [1:0] {
        ST_PASS   = 2'd0,   // forward and record
        ST_CAPT   = 2'd1,   // body locked, one-cycle handover
        ST_REPLAY = 2'd2    // stream from storage, upstream gated
    } lb_state_e;

endpackage

// File: rtl/uloop_store.sv
// Module: uloop_store
// Holds DEPTH recorded micro-ops (payload, tag, taken flag). It has one write
// port and one read port, and compares every stored tag against a probe tag.
// Assumes: the caller masks matches on stale entries; contents are not reset.
module uloop_store #(
    parameter int DEPTH = 28,
    parameter int UOP_W = 32,
    parameter int TAG_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [UOP_W-1:0] wr_uop,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_taken,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [UOP_W-1:0] rd_uop,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_taken,
    input  logic [TAG_W-1:0] probe_tag,
    output logic [DEPTH-1:0] match,
    output logic [TAG_W-1:0] head_tag
);

    logic [UOP_W-1:0] uop_mem   [DEPTH];
    logic [TAG_W-1:0] tag_mem   [DEPTH];
    logic             taken_mem [DEPTH];

    // Record one micro-op per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            uop_mem[wr_addr]   <= wr_uop;
            tag_mem[wr_addr]   <= wr_tag;
            taken_mem[wr_addr] <= wr_taken;
        end
    end

    // Read port for replay.
    always_comb begin
        rd_uop   = uop_mem[rd_addr];
        rd_tag   = tag_mem[rd_addr];
        rd_taken = taken_mem[rd_addr];
    end

    assign head_tag = tag_mem[0];

    // Per-entry tag comparator against the branch target.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cmp
        assign match[gi] = (tag_mem[gi] == probe_tag);
    end

endmodule

// File: rtl/uloop_hit_enc.sv
// Module: uloop_hit_enc
// Finds the highest set bit of a hit vector, which picks the shortest loop
// when more than one entry matches.
// Assumes: idx is meaningful only when any is high.
module uloop_hit_enc #(
    parameter int N = 28,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     hits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Scan upward so that the last (highest) hit wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/uloop_ctrl.sv
// Module: uloop_ctrl
// Mode controller: record pointer, loop candidate tracking, lock decision,
// replay pointer and exit handling.
// Assumes: in_acc is high only for a handshake accepted in ST_PASS.
module uloop_ctrl
    import uloop_pkg::*;
#(
    parameter int DEPTH = 28,
    parameter int TAG_W = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_acc,
    input  logic [TAG_W-1:0] in_tag,
    input  logic             in_taken,
    input  logic [TAG_W-1:0] in_target,
    input  logic             loop_exit,
    input  logic             flush,
    input  logic             out_ready,
    input  logic [DEPTH-1:0] match,
    input  logic [TAG_W-1:0] head_tag,
    output lb_state_e        st,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_addr,
    output logic [IDX_W-1:0] rd_addr
);

    logic [IDX_W-1:0] wr_ptr_q;
    logic [IDX_W-1:0] rd_ptr_q;
    logic             cand_q;
    logic [LEN_W-1:0] cand_len_q;
    logic [LEN_W-1:0] body_len_q;

    logic [DEPTH-1:0] hit_vec;
    logic             hit_any;
    logic [IDX_W-1:0] hit_idx;
    logic [TAG_W-1:0] head_eff;
    logic [LEN_W-1:0] next_len;
    logic             close_loop;
    logic             detect;
    logic             full;
    logic             kill;

    // Only entries already written this recording, plus the incoming branch itself, may hit.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_hit
        assign hit_vec[gi] = (IDX_W'(gi) < wr_ptr_q) ? match[gi]
                           : (IDX_W'(gi) == wr_ptr_q) ? (in_tag == in_target)
                           : 1'b0;
    end

    uloop_hit_enc #(.N(DEPTH)) u_enc (
        .hits (hit_vec),
        .any  (hit_any),
        .idx  (hit_idx)
    );

    // Decision terms for one accepted micro-op.
    always_comb begin
        kill       = flush | loop_exit;
        head_eff   = (wr_ptr_q == '0) ? in_tag : head_tag;
        next_len   = LEN_W'(wr_ptr_q) + LEN_W'(1);
        close_loop = cand_q && in_taken && (in_target == head_eff) && (next_len == cand_len_q);
        detect     = in_taken && hit_any;
        full       = (wr_ptr_q == IDX_W'(DEPTH - 1));
        wr_en      = (st == ST_PASS) && in_acc && !kill && (close_loop || (!detect && !full));
        wr_addr    = wr_ptr_q;
        rd_addr    = rd_ptr_q;
    end

    // Mode and pointer sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_PASS;
            wr_ptr_q   <= '0;
            rd_ptr_q   <= '0;
            cand_q     <= 1'b0;
            cand_len_q <= '0;
            body_len_q <= '0;
        end else begin
            case (st)
                ST_PASS: begin
                    if (kill) begin
                        wr_ptr_q <= '0;
                        cand_q   <= 1'b0;
                    end else if (in_acc) begin
                        if (close_loop) begin
                            body_len_q <= cand_len_q;
                            cand_q     <= 1'b0;
                            wr_ptr_q   <= '0;
                            st         <= ST_CAPT;
                        end else if (detect) begin
                            cand_q     <= 1'b1;
                            cand_len_q <= next_len - LEN_W'(hit_idx);
                            wr_ptr_q   <= '0;
                        end else if (full) begin
                            wr_ptr_q <= '0;
                            cand_q   <= 1'b0;
                        end else begin
                            wr_ptr_q <= wr_ptr_q + IDX_W'(1);
                        end
                    end
                end
                ST_CAPT: begin
                    rd_ptr_q <= '0;
                    st       <= kill ? ST_PASS : ST_REPLAY;
                end
                ST_REPLAY: begin
                    if (kill) begin
                        st <= ST_PASS;
                    end else if (out_ready) begin
                        rd_ptr_q <= (LEN_W'(rd_ptr_q) + LEN_W'(1) == body_len_q) ? '0
                                                                               : rd_ptr_q + IDX_W'(1);
                    end
                end
                default: st <= ST_PASS;
            endcase
        end
    end

    // R2: no lock without a candidate from an earlier pass.
    assert_lock_needs_cand_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PASS && !cand_q) |=> (st != ST_CAPT));

    // R3: a locked body is never empty and never longer than the store.
    assert_len_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_PASS) |-> (body_len_q != '0 && body_len_q <= LEN_W'(DEPTH)));

    // R4: replay read position stays inside the body.
    assert_rd_in_body_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_REPLAY) |-> (LEN_W'(rd_ptr_q) < body_len_q));

    // R5: a stalled replay holds its read position.
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_REPLAY && !out_ready && !kill) |=> ($stable(rd_ptr_q) && st == ST_REPLAY));

    // R7: exit or flush returns to pass-through with a cleared recording.
    assert_exit_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (st == ST_PASS && wr_ptr_q == '0 && !cand_q));

endmodule

// File: rtl/uop_loop_buffer.sv
// Module: uop_loop_buffer (top)
// Forwards decoded micro-ops and records them. It locks a short backward loop
// that has been seen twice and replays it with the upstream stages gated.
// Assumes: after replay ends, upstream resumes at the right place (it is
// steered by the exit/flush source).
module uop_loop_buffer
    import uloop_pkg::*;
#(
    parameter int DEPTH = 28,
    parameter int UOP_W = 32,
    parameter int TAG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [UOP_W-1:0] in_uop,
    input  logic [TAG_W-1:0] in_tag,
    input  logic             in_taken,
    input  logic [TAG_W-1:0] in_target,
    input  logic             loop_exit,
    input  logic             flush,
    output logic             in_ready,
    output logic             out_valid,
    output logic [UOP_W-1:0] out_uop,
    output logic [TAG_W-1:0] out_tag,
    output logic             out_taken,
    input  logic             out_ready,
    output logic             gate_fetch,
    output logic             gate_bpred,
    output logic             gate_decode
);

    localparam int IDX_W = $clog2(DEPTH);

    lb_state_e        st;
    logic             wr_en;
    logic [IDX_W-1:0] wr_addr;
    logic [IDX_W-1:0] rd_addr;
    logic [UOP_W-1:0] rd_uop;
    logic [TAG_W-1:0] rd_tag;
    logic             rd_taken;
    logic [DEPTH-1:0] match;
    logic [TAG_W-1:0] head_tag;
    logic             in_acc;

    assign in_acc = in_valid && in_ready;

    uloop_store #(.DEPTH(DEPTH), .UOP_W(UOP_W), .TAG_W(TAG_W)) u_store (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_uop    (in_uop),
        .wr_tag    (in_tag),
        .wr_taken  (in_taken),
        .rd_addr   (rd_addr),
        .rd_uop    (rd_uop),
        .rd_tag    (rd_tag),
        .rd_taken  (rd_taken),
        .probe_tag (in_target),
        .match     (match),
        .head_tag  (head_tag)
    );

    uloop_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_acc    (in_acc),
        .in_tag    (in_tag),
        .in_taken  (in_taken),
        .in_target (in_target),
        .loop_exit (loop_exit),
        .flush     (flush),
        .out_ready (out_ready),
        .match     (match),
        .head_tag  (head_tag),
        .st        (st),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr)
    );

    // Output source select: decoder stream in pass-through, storage in replay.
    always_comb begin
        if (st == ST_PASS) begin
            out_valid = in_valid;
            out_uop   = in_uop;
            out_tag   = in_tag;
            out_taken = in_taken;
            in_ready  = out_ready;
        end else begin
            out_valid = (st == ST_REPLAY);
            out_uop   = rd_uop;
            out_tag   = rd_tag;
            out_taken = rd_taken;
            in_ready  = 1'b0;
        end
    end

    // Upstream gates follow the replay mode.
    assign gate_fetch  = (st == ST_REPLAY);
    assign gate_bpred  = (st == ST_REPLAY);
    assign gate_decode = (st == ST_REPLAY);

    // R6: a gated decoder is never asked for input.
    assert_gate_blocks_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_decode || gate_fetch || gate_bpred) |-> !in_ready);

    // R4: replay always presents a valid micro-op.
    assert_replay_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_REPLAY) |-> out_valid);

endmodule

// File: tb/test_uop_loop_buffer.sv
// Directed bench for uop_loop_buffer: one task per scenario, each task checking its own results.
module test_uop_loop_buffer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_uop = '0;
    logic [15:0] in_tag = '0;
    logic        in_taken = 1'b0;
    logic [15:0] in_target = '0;
    logic        loop_exit = 1'b0;
    logic        flush = 1'b0;
    logic        out_ready = 1'b1;
    logic        in_ready;
    logic        out_valid;
    logic [31:0] out_uop;
    logic [15:0] out_tag;
    logic        out_taken;
    logic        gate_fetch, gate_bpred, gate_decode;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    uop_loop_buffer i_uop_loop_buffer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uop(in_uop), .in_tag(in_tag),
        .in_taken(in_taken), .in_target(in_target), .loop_exit(loop_exit), .flush(flush),
        .in_ready(in_ready), .out_valid(out_valid), .out_uop(out_uop), .out_tag(out_tag),
        .out_taken(out_taken), .out_ready(out_ready), .gate_fetch(gate_fetch),
        .gate_bpred(gate_bpred), .gate_decode(gate_decode)
    );

    function automatic logic [31:0] uop_of(input logic [15:0] tag);
        return {tag ^ 16'h3C5A, tag};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] gates();
        return {gate_fetch, gate_bpred, gate_decode};
    endfunction

    // Drive one micro-op and check it is forwarded unchanged with gates low.
    task automatic send(input logic [15:0] tag, input bit taken, input logic [15:0] tgt,
                        input bit fl, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_uop = uop_of(tag); in_tag = tag;
        in_taken = taken; in_target = tgt; flush = fl; out_ready = 1'b1;
        #1;
        chk(out_valid && in_ready && out_uop == uop_of(tag) && out_tag == tag && out_taken == taken,
            req, {out_valid, in_ready, out_tag}, {2'b11, tag});
        chk(gates() == 3'b000, "R6", gates(), 3'b000);
        @(posedge clk); #1;
        in_valid = 1'b0; in_taken = 1'b0; flush = 1'b0;
    endtask

    // One pass of a loop body: base .. base+len-1, branch back on the last entry.
    task automatic pass_body(input logic [15:0] base, input int len, input bit fl_close, input string req);
        for (int i = 0; i < len; i++)
            send(base + 16'(i), (i == len - 1), base, fl_close && (i == len - 1), req);
    endtask

    task automatic flush_idle();
        @(negedge clk); in_valid = 1'b0; flush = 1'b1;
        @(posedge clk); #1; flush = 1'b0;
    endtask

    // Check the handover cycle, then the replay order over laps, with an optional stall.
    task automatic expect_replay(input logic [15:0] base, input int len, input int laps, input int stall_at);
        @(negedge clk);
        chk(!out_valid && !in_ready, "R2 handover", {out_valid, in_ready}, 2'b00);
        chk(gates() == 3'b000, "R6 handover", gates(), 3'b000);
        for (int j = 0; j < laps * len; j++) begin
            @(negedge clk);
            chk(out_valid && out_tag == base + 16'(j % len) && out_uop == uop_of(base + 16'(j % len))
                && out_taken == (j % len == len - 1), "R4 order", out_tag, base + 16'(j % len));
            chk(gates() == 3'b111 && !in_ready, "R6 replay", {gates(), in_ready}, 4'b1110);
            if (j == stall_at) begin
                out_ready = 1'b0;
                for (int s = 0; s < 3; s++) begin
                    @(negedge clk);
                    chk(out_valid && out_tag == base + 16'(j % len), "R5 stall", out_tag, base + 16'(j % len));
                end
                out_ready = 1'b1;
            end
        end
    endtask

    task automatic leave(input bit by_flush, input string req);
        @(negedge clk);
        if (by_flush) flush = 1'b1; else loop_exit = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0; loop_exit = 1'b0;
        @(negedge clk);
        chk(gates() == 3'b000 && !out_valid && in_ready, req, {gates(), out_valid, in_ready}, 5'b00001);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(gates() == 3'b000 && !out_valid && in_ready, "R6 reset", {gates(), out_valid, in_ready}, 5'b00001);
    endtask

    task automatic t_forward();
        for (int i = 0; i < 6; i++) send(16'h0010 + 16'(i), 1'b0, 16'h0, 1'b0, "R1 forward");
        send(16'h0020, 1'b1, 16'h0900, 1'b0, "R1 forward taken no hit");
        @(negedge clk); out_ready = 1'b0; in_valid = 1'b1; #1;
        chk(!in_ready, "R1 ready follows", in_ready, 1'b0);
        @(posedge clk); #1; in_valid = 1'b0; out_ready = 1'b1;
    endtask

    task automatic t_basic_loop();
        for (int i = 0; i < 3; i++) send(16'h0100 + 16'(i), 1'b0, 16'h0, 1'b0, "R1 preamble");
        pass_body(16'h0200, 5, 1'b0, "R2 first pass forwarded");
        pass_body(16'h0200, 5, 1'b0, "R2 second pass forwarded");
        expect_replay(16'h0200, 5, 3, -1);
        leave(1'b0, "R7 loop exit");
        pass_body(16'h0200, 5, 1'b0, "R7 single pass after exit");
        @(negedge clk);
        chk(gates() == 3'b000 && !out_valid, "R7 no lock after one pass", gates(), 3'b000);
    endtask

    task automatic t_stall();
        flush_idle();
        pass_body(16'h0300, 4, 1'b0, "R5 pass");
        pass_body(16'h0300, 4, 1'b0, "R5 pass");
        expect_replay(16'h0300, 4, 2, 2);
        leave(1'b1, "R7 flush in replay");
    endtask

    task automatic t_capacity();
        flush_idle();
        pass_body(16'h0400, 28, 1'b0, "R3 pass 28");
        pass_body(16'h0400, 28, 1'b0, "R3 pass 28");
        expect_replay(16'h0400, 28, 2, -1);
        leave(1'b1, "R7 flush after 28");
        flush_idle();
        for (int k = 0; k < 3; k++) pass_body(16'h0500, 29, 1'b0, "R3 body 29 forwarded");
        repeat (2) begin
            @(negedge clk);
            chk(gates() == 3'b000 && !out_valid && in_ready, "R3 no lock 29", gates(), 3'b000);
        end
    endtask

    task automatic t_flush_close();
        flush_idle();
        pass_body(16'h0600, 3, 1'b0, "R8 pass");
        pass_body(16'h0600, 3, 1'b1, "R8 flush on close");
        @(negedge clk);
        chk(gates() == 3'b000 && !out_valid && in_ready, "R8 flush wins", {gates(), out_valid, in_ready}, 5'b00001);
        pass_body(16'h0600, 3, 1'b0, "R8 third pass forwarded");
        pass_body(16'h0600, 3, 1'b0, "R8 fourth pass forwarded");
        expect_replay(16'h0600, 3, 1, -1);
        leave(1'b0, "R7 exit");
    endtask

    task automatic t_self_loop();
        flush_idle();
        send(16'h0700, 1'b1, 16'h0700, 1'b0, "R2 self loop pass");
        send(16'h0700, 1'b1, 16'h0700, 1'b0, "R2 self loop pass");
        expect_replay(16'h0700, 1, 4, -1);
        leave(1'b1, "R7 flush self loop");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_forward();
        t_basic_loop();
        t_stall();
        t_capacity();
        t_flush_close();
        t_self_loop();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule